// File: doc/BRIEF.md
# Echo-Checked Single-Wire Message Transmitter

This block sends one message at a time onto a half-duplex single-wire bus. On that bus the line transceiver hands every byte placed on the wire back to the receive path. Message bytes arrive on a valid/ready stream, and a flag marks the final byte. When the message begins, the block throws away any bytes already waiting on the receive side. It then sends the message in slices of no more than `CHUNK_MAX` bytes (15 by default). After each slice it takes in the same number of returned bytes and checks each one against the byte it sent. A modulo-256 sum of the message may be added as a trailing byte.

The byte serializer and deserializer live outside the block and connect through two byte streams. Every message ends with one of two outcomes. A `done` pulse means every slice came back intact. An `err` pulse carries the reason (wrong returned byte or echo timeout) and the zero-based index of the slice that failed. After an error the block sends nothing more. It accepts and discards the rest of the message from the input stream up to its final byte, then returns to idle.

Top module: `echo_line_tx`

## Requirements
- R1: After reset and whenever no message is in progress, `busy`, `tx_valid`, `in_ready`, `rx_ready`, `done` and `err` are all low. A message starts only when `in_valid` is seen high while idle.
- R2: When a message starts, receive bytes already presented on `rx_valid` are accepted and discarded until `rx_valid` goes low. They take no part in the echo comparison.
- R3: Message bytes leave on `tx_data` unchanged and in the order they were accepted. `tx_data` stays stable while `tx_valid` is high and `tx_ready` is low.
- R4: `cksum_en` is sampled when the message starts. If it is 1, one extra byte equal to the sum of all message bytes modulo 256 is sent after the last message byte. If it is 0, no extra byte is sent.
- R5: A slice holds at most `CHUNK_MAX` bytes, and the checksum byte counts toward the slice it falls in. The first byte of a slice is not sent until every echo byte of the slice before it has been received. The block never accepts input and sends in the same cycle.
- R6: If any returned byte of a slice differs from the byte sent in that position, the block raises `err` for one cycle with `err_timeout` = 0. This happens after the whole slice's echo has been collected.
- R7: While the block waits for echo bytes after a slice has been fully sent, `ECHO_TMO` consecutive cycles with no echo byte raise `err` with `err_timeout` = 1.
- R8: After `err`, no further byte is sent. If the message's last byte has not yet been accepted, input bytes are accepted and discarded up to and including the one with `in_last` = 1. The block then goes idle.
- R9: When the echo of the final slice matches, `done` pulses for one cycle and `busy` falls in that same cycle. Each message produces exactly one `done` or one `err`, never both.
- R10: `err_chunk` gives the zero-based index of the failing slice, counted in message order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cksum_en | input | 1 | Append modulo-256 sum byte (sampled at message start) |
| in_valid | input | 1 | Message byte available |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Marks the final byte of the message |
| in_ready | output | 1 | Block accepts a message byte |
| tx_valid | output | 1 | Byte offered to the serializer |
| tx_data | output | 8 | Byte to put on the wire |
| tx_ready | input | 1 | Serializer takes the byte |
| rx_valid | input | 1 | Byte received from the wire |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block takes the received byte |
| busy | output | 1 | Message in progress |
| done | output | 1 | One-cycle pulse: message sent and fully echo-verified |
| err | output | 1 | One-cycle pulse: message aborted |
| err_timeout | output | 1 | With `err`: 1 = echo timeout, 0 = echo mismatch |
| err_chunk | output | CIDX_W | With `err`: index of the failing slice |

## Verification
The bench puts stale bytes on the receive path before a message. A block that skipped the drain would treat them as echo and report a false mismatch. Messages of exactly 15 bytes with the checksum turned on force the checksum byte into a slice of its own, where a boundary slip would drop it or send 16 bytes. The echo comes back with a few cycles of latency, so some echo bytes arrive while the slice is still going out. A block that sent the next slice too early would break the rule that the slice before it must be fully echoed first. One byte of the echo is corrupted, or dropped, inside the second slice. This exposes a wrong slice index, a wrong error kind, bytes sent after the abort, and leftover input that would wrongly start a phantom message.

// File: rtl/elt_pkg.sv
package elt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_FILL,
        ST_SEND,
        ST_ECHO,
        ST_SKIP
    } elt_state_e;

    typedef struct packed {
        logic       timeout;
        logic [7:0] chunk;
    } elt_fault_t;

    function automatic logic [7:0] sum8(input logic [7:0] acc, input logic [7:0] b);
        return acc + b;
    endfunction

endpackage

// File: rtl/elt_chunk_buf.sv
module elt_chunk_buf #(
    parameter int DEPTH = 15,
    localparam int IW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    input  logic [IW-1:0] cmp_idx,
    output logic [7:0]    cmp_data
);
    logic [7:0] slot [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (wr_idx < IW'(DEPTH))) begin
            slot[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_data  = (rd_idx  < IW'(DEPTH)) ? slot[rd_idx]  : 8'h00;
        cmp_data = (cmp_idx < IW'(DEPTH)) ? slot[cmp_idx] : 8'h00;
    end
endmodule

// File: rtl/elt_echo_timer.sv
module elt_echo_timer #(
    parameter int LIMIT = 64,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic kick,
    output logic expired
);
    logic [CW-1:0] cnt;

    assign expired = (cnt == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || !run || kick) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/echo_line_tx.sv
module echo_line_tx
    import elt_pkg::*;
#(
    parameter int CHUNK_MAX = 15,
    parameter int ECHO_TMO  = 64,
    parameter int CIDX_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cksum_en,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              err_timeout,
    output logic [CIDX_W-1:0] err_chunk
);
    localparam int IW = $clog2(CHUNK_MAX + 1);
    localparam logic [IW-1:0] FULL = IW'(CHUNK_MAX);

    elt_state_e        st;
    logic [IW-1:0]     len, tx_idx, rx_idx;
    logic [7:0]        sum;
    logic              ck_en_q, ck_pend, last_seen, mism;
    logic [CIDX_W-1:0] chunk_q;

    logic       in_acc, rx_acc, echo_acc, wr_en, tmo_hit, put_ck;
    logic [7:0] wr_data, cmp_data;

    // stream control
    assign put_ck   = (st == ST_FILL) && ck_pend && (len < FULL);
    assign in_ready = ((st == ST_FILL) && !last_seen && (len < FULL)) || (st == ST_SKIP);
    assign in_acc   = in_valid && in_ready;
    assign tx_valid = (st == ST_SEND);
    assign rx_ready = (st == ST_DRAIN) ||
                      (((st == ST_SEND) || (st == ST_ECHO)) && (rx_idx < len));
    assign rx_acc   = rx_valid && rx_ready;
    assign echo_acc = rx_acc && (st != ST_DRAIN);
    assign busy     = (st != ST_IDLE);

    assign wr_en   = put_ck || ((st == ST_FILL) && in_acc);
    assign wr_data = ck_pend ? sum : in_data;

    elt_chunk_buf #(.DEPTH(CHUNK_MAX)) u_buf (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_idx   (len),
        .wr_data  (wr_data),
        .rd_idx   (tx_idx),
        .rd_data  (tx_data),
        .cmp_idx  (rx_idx),
        .cmp_data (cmp_data)
    );

    elt_echo_timer #(.LIMIT(ECHO_TMO)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .run     (st == ST_ECHO),
        .kick    (echo_acc),
        .expired (tmo_hit)
    );

    elt_fault_t fault;
    always_comb begin
        fault.timeout = (rx_idx != len);
        fault.chunk   = 8'(chunk_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            len         <= '0;
            tx_idx      <= '0;
            rx_idx      <= '0;
            sum         <= '0;
            ck_en_q     <= 1'b0;
            ck_pend     <= 1'b0;
            last_seen   <= 1'b0;
            mism        <= 1'b0;
            chunk_q     <= '0;
            done        <= 1'b0;
            err         <= 1'b0;
            err_timeout <= 1'b0;
            err_chunk   <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;

            // echo collection runs while sending and while waiting
            if (echo_acc) begin
                rx_idx <= rx_idx + 1'b1;
                if (rx_data != cmp_data) mism <= 1'b1;
            end

            unique case (st)
                ST_IDLE: if (in_valid) begin
                    st        <= ST_DRAIN;
                    ck_en_q   <= cksum_en;
                    sum       <= '0;
                    chunk_q   <= '0;
                    last_seen <= 1'b0;
                    ck_pend   <= 1'b0;
                end
                ST_DRAIN: if (!rx_valid) begin
                    st     <= ST_FILL;
                    len    <= '0;
                    tx_idx <= '0;
                    rx_idx <= '0;
                    mism   <= 1'b0;
                end
                ST_FILL: begin
                    if (put_ck) begin
                        len     <= len + 1'b1;
                        ck_pend <= 1'b0;
                        st      <= ST_SEND;
                    end else if ((last_seen && !ck_pend) || (len == FULL)) begin
                        st <= ST_SEND;
                    end else if (in_acc) begin
                        len <= len + 1'b1;
                        sum <= sum8(sum, in_data);
                        if (in_last) begin
                            last_seen <= 1'b1;
                            ck_pend   <= ck_en_q;
                        end
                    end
                end
                ST_SEND: if (tx_ready) begin
                    tx_idx <= tx_idx + 1'b1;
                    if (tx_idx == len - 1'b1) st <= ST_ECHO;
                end
                ST_ECHO: begin
                    if ((rx_idx == len && mism) || (rx_idx != len && tmo_hit)) begin
                        err         <= 1'b1;
                        err_timeout <= fault.timeout;
                        err_chunk   <= CIDX_W'(fault.chunk);
                        st          <= last_seen ? ST_IDLE : ST_SKIP;
                    end else if (rx_idx == len) begin
                        if (last_seen && !ck_pend) begin
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end else begin
                            st      <= ST_FILL;
                            len     <= '0;
                            tx_idx  <= '0;
                            rx_idx  <= '0;
                            mism    <= 1'b0;
                            chunk_q <= chunk_q + 1'b1;
                        end
                    end
                end
                ST_SKIP: if (in_acc && in_last) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/elt_checker.sv
module elt_checker (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       busy,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       rx_ready,
    input logic       done,
    input logic       err
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!tx_valid && !rx_ready && !in_ready));

    assert_start_on_input_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(in_valid));

    assert_tx_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_fill_send_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid && in_ready));

    assert_no_tx_after_err_R8: assert property (@(posedge clk) disable iff (rst)
        err |-> !tx_valid);

    assert_single_outcome_R9: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind echo_line_tx elt_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .busy     (busy),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .rx_ready (rx_ready),
    .done     (done),
    .err      (err)
);

// File: tb/sim_echo_line_tx.sv
module sim_echo_line_tx;
    localparam int CHUNK = 15;
    localparam int TMO   = 64;
    localparam int LAT   = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cksum_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready;
    logic       busy, done, err, err_timeout;
    logic [7:0] err_chunk;

    always #10 clk = ~clk;

    echo_line_tx #(.CHUNK_MAX(CHUNK), .ECHO_TMO(TMO), .CIDX_W(8)) u0 (
        .clk(clk), .rst(rst), .cksum_en(cksum_en),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .busy(busy), .done(done), .err(err), .err_timeout(err_timeout), .err_chunk(err_chunk)
    );

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    // reference model state
    logic [7:0] msg_d[$];
    logic       msg_l[$];
    logic [7:0] stale_q[$];
    logic [7:0] echo_q[$];
    int         echo_t[$];
    logic [7:0] exp_tx[$];
    int  sent, echo_used, corrupt_at, drop_at, n_done, n_err;
    logic got_to;
    logic [7:0] got_chunk;
    bit  throttle;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        bit from_stale;
        @(negedge clk);
        in_valid = (msg_d.size() > 0);
        in_data  = (msg_d.size() > 0) ? msg_d[0] : 8'h00;
        in_last  = (msg_l.size() > 0) ? msg_l[0] : 1'b0;
        tx_ready = throttle ? ((cyc % 3) != 0) : 1'b1;
        from_stale = 1'b0;
        if (stale_q.size() > 0) begin
            rx_valid = 1'b1; rx_data = stale_q[0]; from_stale = 1'b1;
        end else if (echo_q.size() > 0 && echo_t[0] <= cyc) begin
            rx_valid = 1'b1; rx_data = echo_q[0];
        end else begin
            rx_valid = 1'b0; rx_data = 8'h00;
        end
        #1;
        if (tx_valid && tx_ready) begin
            // R5: a new slice waits for the whole previous echo
            if (sent > 0 && (sent % CHUNK) == 0)
                chk(echo_used == sent, "R5 slice gating", echo_used, sent);
            if (exp_tx.size() == 0) begin
                chk(1'b0, "R8 byte sent after end", tx_data, -1);
            end else begin
                chk(tx_data == exp_tx[0], "R3 tx byte", tx_data, exp_tx[0]);
                void'(exp_tx.pop_front());
            end
            if (sent != drop_at) begin
                echo_q.push_back((sent == corrupt_at) ? (tx_data ^ 8'h5A) : tx_data);
                echo_t.push_back(cyc + LAT);
            end
            sent++;
        end
        if (in_valid && in_ready) begin
            void'(msg_d.pop_front());
            void'(msg_l.pop_front());
        end
        if (rx_valid && rx_ready) begin
            if (from_stale) void'(stale_q.pop_front());
            else begin
                void'(echo_q.pop_front());
                void'(echo_t.pop_front());
                echo_used++;
            end
        end
        if (done) n_done++;
        if (err) begin
            n_err++; got_to = err_timeout; got_chunk = err_chunk;
        end
        if (done && err) chk(1'b0, "R9 done with err", 1, 0);
        cyc++;
    endtask

    // kind: 0 = pass, 1 = mismatch, 2 = timeout; pos = global byte index
    task automatic run_msg(input string name, input int n, input int seed, input bit ck,
                           input int kind, input int pos, input int nstale, input bit thr);
        logic [7:0] full[$];
        int s = 0;
        int limit, fc, guard;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'((seed + i * 37) & 8'hFF);
            full.push_back(b);
            msg_d.push_back(b);
            msg_l.push_back(i == n - 1);
            s += b;
        end
        if (ck) full.push_back(8'(s % 256));
        for (int i = 0; i < nstale; i++) stale_q.push_back(8'(8'hC0 + i));
        fc = (kind == 0) ? -1 : pos / CHUNK;
        limit = (kind == 1) ? (((fc + 1) * CHUNK < full.size()) ? (fc + 1) * CHUNK : full.size())
                            : full.size();
        for (int i = 0; i < limit; i++) exp_tx.push_back(full[i]);
        sent = 0; echo_used = 0; n_done = 0; n_err = 0;
        corrupt_at = (kind == 1) ? pos : -1;
        drop_at    = (kind == 2) ? pos : -1;
        cksum_en = ck; throttle = thr;
        guard = 0;
        tick();
        while ((busy || msg_d.size() > 0 || (n_done + n_err) == 0) && guard < 5000) begin
            tick(); guard++;
        end
        if (guard >= 5000) chk(1'b0, {"watchdog ", name}, guard, 0);
        repeat (4) tick();
        chk(exp_tx.size() == 0, {"R3 all bytes sent ", name}, exp_tx.size(), 0);
        chk(stale_q.size() == 0, {"R2 stale drained ", name}, stale_q.size(), 0);
        chk(msg_d.size() == 0, {"R8 input consumed ", name}, msg_d.size(), 0);
        chk(!busy, {"R1 idle after ", name}, busy, 0);
        if (kind == 0) begin
            chk(n_done == 1 && n_err == 0, {"R9 one done ", name}, n_done, 1);
            chk(sent == full.size(), {"R4 byte count ", name}, sent, full.size());
        end else begin
            chk(n_err == 1 && n_done == 0, {"R6 one err ", name}, n_err, 1);
            chk(got_to == (kind == 2), {"R7 err kind ", name}, got_to, kind == 2);
            chk(int'(got_chunk) == fc, {"R10 err slice ", name}, got_chunk, fc);
        end
        exp_tx.delete(); echo_q.delete(); echo_t.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !tx_valid && !in_ready && !rx_ready && !done && !err,
            "R1 reset state", busy, 0);
        @(negedge clk);
        rst = 1'b0;
        run_msg("short",      3, 8'h11, 1'b0, 0, 0, 0, 1'b0);
        run_msg("cksum",      5, 8'h20, 1'b1, 0, 0, 0, 1'b0);   // R4
        run_msg("exact15",   15, 8'h03, 1'b0, 0, 0, 0, 1'b0);   // R5
        run_msg("ck_alone",  15, 8'h40, 1'b1, 0, 0, 0, 1'b0);   // R4 R5
        run_msg("three",     40, 8'h07, 1'b1, 0, 0, 0, 1'b0);   // R5
        run_msg("stale",      4, 8'h55, 1'b0, 0, 0, 3, 1'b0);   // R2
        run_msg("throttle",  20, 8'h99, 1'b1, 0, 0, 0, 1'b1);   // R3
        run_msg("wrap",       3, 8'hFF, 1'b1, 0, 0, 0, 1'b0);   // R4
        run_msg("mism_c1",   40, 8'h31, 1'b1, 1, 20, 0, 1'b0);  // R6 R8 R10
        run_msg("after_err",  6, 8'h62, 1'b0, 0, 0, 0, 1'b0);   // R1
        run_msg("tmo_c0",    10, 8'h0A, 1'b0, 2, 5, 0, 1'b0);   // R7
        run_msg("tmo_c1",    20, 8'h77, 1'b1, 2, 17, 0, 1'b0);  // R7 R10
        run_msg("mism_last",  8, 8'h15, 1'b1, 1, 8, 0, 1'b0);   // R6 on checksum byte
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule